// File: doc/BRIEF.md
# Pulse Width and Edge Capture Timer

This block is a single timer channel. It pairs an up-counter with an edge detector on one measurement input. A 4-bit mode selects what the channel does with the edges it sees:

- It can time a high pulse, a low pulse or a full period of the input.
- It can time a high pulse and the period that contains it, both in one pass.
- It can copy the counter into a result register on chosen edges. In these capture modes the counter either keeps running or restarts from each capture.

Each finished measurement or capture raises a one-cycle strobe. An overflow flag reports when the counter wrapped during a measurement.

The counter advances only in cycles where the count enable is high. An upstream prescaler can therefore set the time base. The measurement input may be asynchronous, because it passes through a two-flop synchroniser before any edge is detected.

Modes 0000 through 0100 do not belong to this block. In those modes the channel stays quiet: the counter sits at zero and any measurement in progress is abandoned.

Top module: `pwc_capture_timer`

## Requirements
- R1: A change on `meas_in` is acted on after exactly three rising clock edges. For example, in a capture mode `valid` is low after the second edge that follows the change and high after the third.
- R2: While `rst_n` is low, `result`, `width_hi`, `valid` and `ovf` are all 0.
- R3: Mode 0101 times the high pulse and mode 0110 times the low pulse. The start edge (rising for 0101, falling for 0110) clears the measurement. The opposite edge that follows ends it and writes the number of enabled clock cycles between the two edges into `result`. After that the channel waits for a fresh start edge.
- R4: Mode 0111 times from rising edge to rising edge, and mode 1000 from falling edge to falling edge. Every such edge after the first one reports a period and also starts the next one, so periods are reported back to back.
- R5: Mode 1001 times from one rising edge to the next and reports that period in `result` with `valid`. The falling edge in between writes the high width into `width_hi` and raises no strobe. `width_hi` changes in no other mode.
- R6: Modes 1010, 1011 and 1100 copy the free-running counter into `result` on the rising edge, the falling edge, or both edges respectively. The difference between two captures equals the number of enabled cycles between the two edges.
- R7: Modes 1101, 1110 and 1111 capture on the rising edge, the falling edge, or both edges respectively, and restart the count at every capture. Each `result` is therefore the number of enabled cycles since the previous capture.
- R8: Cycles in which `cnt_en` is low are left out of every measured width, period and capture.
- R9: `ovf` goes high when the counter wraps during a measurement that is under way (or at any time in a capture mode). It is still high in the cycle where `valid` reports that measurement, and it drops on the cycle after.
- R10: In modes 0000 through 0100, `valid` stays low and any measurement in progress is dropped. A later switch back to a measuring mode waits for a new start edge.
- R11: `valid` lasts one cycle per event, and `result` changes only in a cycle where `valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter advances in cycles where this is high |
| meas_in | input | 1 | Measurement input, may be asynchronous |
| mode | input | 4 | Function select, 0101..1111 active |
| result | output | CNT_W | Latest width, period or captured count |
| width_hi | output | CNT_W | High width captured in mode 1001 |
| valid | output | 1 | One-cycle strobe when `result` is updated |
| ovf | output | 1 | Counter wrapped since the last strobe |

## Verification
A wrong armed state shows at the ports as a spurious or missing `valid` within three cycles of the edge concerned. It shows most plainly in modes 0101, 0110 and after a mode change. A miscounted or wrongly cleared counter shows up as a `result` that is off by the error in the very next strobe. In the free-run capture modes the same error appears as a wrong difference between two consecutive captures. A faulty overflow path shows as `ovf` being absent at the strobe of a long pulse, or still present one cycle after it.

// File: rtl/pwc_capture_timer.sv
module pwc_capture_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             meas_in,
  input  logic [3:0]       mode,
  output logic [CNT_W-1:0] result,
  output logic [CNT_W-1:0] width_hi,
  output logic             valid,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [3:0] M_HIGH   = 4'b0101;
  localparam logic [3:0] M_LOW    = 4'b0110;
  localparam logic [3:0] M_PER_R  = 4'b0111;
  localparam logic [3:0] M_PER_F  = 4'b1000;
  localparam logic [3:0] M_HI_PER = 4'b1001;
  localparam logic [3:0] M_FR_R   = 4'b1010;
  localparam logic [3:0] M_FR_F   = 4'b1011;
  localparam logic [3:0] M_FR_B   = 4'b1100;
  localparam logic [3:0] M_CL_R   = 4'b1101;
  localparam logic [3:0] M_CL_F   = 4'b1110;
  localparam logic [3:0] M_CL_B   = 4'b1111;

  logic sync_a, sync_b, sync_prev;
  logic armed;
  logic [CNT_W-1:0] cnt;

  logic rise, fall, idle, capturing;
  logic start_ev, end_ev, hi_ev, cap_ev, cap_clr, one_shot;
  logic load, wrap;

  assign rise      = sync_b & ~sync_prev;
  assign fall      = ~sync_b & sync_prev;
  assign idle      = (mode < M_HIGH);
  assign capturing = (mode >= M_FR_R);

  always_comb begin
    start_ev = 1'b0;
    end_ev   = 1'b0;
    hi_ev    = 1'b0;
    cap_ev   = 1'b0;
    cap_clr  = 1'b0;
    one_shot = 1'b0;
    unique case (mode)
      M_HIGH:   begin start_ev = rise; end_ev = fall & armed; one_shot = 1'b1; end
      M_LOW:    begin start_ev = fall; end_ev = rise & armed; one_shot = 1'b1; end
      M_PER_R:  begin start_ev = rise; end_ev = rise & armed; end
      M_PER_F:  begin start_ev = fall; end_ev = fall & armed; end
      M_HI_PER: begin start_ev = rise; end_ev = rise & armed; hi_ev = fall & armed; end
      M_FR_R:   cap_ev = rise;
      M_FR_F:   cap_ev = fall;
      M_FR_B:   cap_ev = rise | fall;
      M_CL_R:   begin cap_ev = rise;        cap_clr = 1'b1; end
      M_CL_F:   begin cap_ev = fall;        cap_clr = 1'b1; end
      M_CL_B:   begin cap_ev = rise | fall; cap_clr = 1'b1; end
      default:  ;
    endcase
  end

  assign load = start_ev | (cap_ev & cap_clr);
  assign wrap = cnt_en & (cnt == CNT_TOP) & ~load & ~idle & (armed | capturing);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync_a    <= meas_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (idle) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (load) cnt <= {{(CNT_W-1){1'b0}}, cnt_en};
      else      cnt <= cnt + {{(CNT_W-1){1'b0}}, cnt_en};
      if (start_ev)               armed <= 1'b1;
      else if (end_ev && one_shot) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      width_hi <= '0;
      valid    <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      valid <= end_ev | cap_ev;
      if (end_ev | cap_ev) result <= cnt;
      if (hi_ev) width_hi <= cnt;
      ovf <= wrap | (ovf & ~valid);
    end
  end

endmodule

// File: rtl/pwc_capture_timer_sva.sv
module pwc_capture_timer_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       mode,
  input logic [CNT_W-1:0] result,
  input logic [CNT_W-1:0] width_hi,
  input logic             valid,
  input logic             ovf
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  assert_idle_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode < 4'd5) |=> !valid);

  assert_result_needs_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$stable(result) |-> valid);

  assert_ovf_clears_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $fell(ovf) |-> $past(valid));

  assert_hi_only_in_combined_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$stable(width_hi) |-> ($past(mode) == 4'b1001));

endmodule

bind pwc_capture_timer pwc_capture_timer_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .mode(mode), .result(result),
  .width_hi(width_hi), .valid(valid), .ovf(ovf)
);

// File: tb/tb_pwc_capture_timer.sv
module tb_pwc_capture_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 11;

  localparam int V_MODE [NV] = '{5, 6, 7, 8, 9, 10, 11, 12, 13, 14, 15};
  localparam int V_H    [NV] = '{7, 6, 4, 10, 8, 5, 9, 6, 3, 12, 7};
  localparam int V_L    [NV] = '{5, 9, 11, 3, 6, 7, 4, 6, 8, 5, 10};
  localparam int V_CNT  [NV] = '{2, 1, 1, 1, 1, 2, 2, 4, 2, 2, 4};
  localparam int V_EXP  [NV] = '{7, 9, 15, 13, 14, 12, 13, 18, 11, 17, 7};
  localparam int V_DIFF [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b1;
  logic meas_in = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic [W-1:0] result, width_hi;
  logic valid, ovf;

  int checks = 0;
  int errors = 0;
  int vtot = 0;
  logic [W-1:0] log_r [0:255];

  pwc_capture_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .meas_in(meas_in),
    .mode(mode), .result(result), .width_hi(width_hi), .valid(valid), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && valid) begin
    log_r[vtot[7:0]] <= result;
    vtot <= vtot + 1;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic go_mode(int m);
    mode = 4'd0; tick(4);
    mode = 4'(m); tick(4);
  endtask

  task automatic pattern(int h, int l);
    repeat (2) begin
      meas_in = 1'b1; tick(h);
      meas_in = 1'b0; tick(l);
    end
    tick(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int base, r0;
    tick(3);
    chk("R2 result in reset", int'(result), 0);
    chk("R2 width_hi in reset", int'(width_hi), 0);
    chk("R2 valid in reset", int'(valid), 0);
    chk("R2 ovf in reset", int'(ovf), 0);
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < NV; i++) begin
      go_mode(V_MODE[i]);
      base = vtot;
      pattern(V_H[i], V_L[i]);
      chk($sformatf("R3/R4/R5/R6/R7 strobes mode %0d", V_MODE[i]), vtot - base, V_CNT[i]);
      if (V_DIFF[i] != 0)
        chk($sformatf("R6 capture difference mode %0d", V_MODE[i]),
            int'(log_r[(vtot-1) & 255] - log_r[base & 255]), V_EXP[i]);
      else
        chk($sformatf("R3/R4/R5/R7 value mode %0d", V_MODE[i]), int'(log_r[(vtot-1) & 255]), V_EXP[i]);
      if (V_MODE[i] == 9) chk("R5 high width", int'(width_hi), V_H[i]);
      if (i == 0) chk("R9 no ovf on short pulse", int'(ovf), 0);
    end

    // R1 latency and R11 single-cycle strobe
    go_mode(13);
    meas_in = 1'b1;
    tick(2);
    chk("R1 no strobe after two edges", int'(valid), 0);
    tick(1);
    chk("R1 strobe after third edge", int'(valid), 1);
    r0 = int'(result);
    tick(1);
    chk("R11 strobe one cycle", int'(valid), 0);
    tick(3);
    chk("R11 result holds", int'(result), r0);
    meas_in = 1'b0; tick(4);

    // R8 enable gating
    go_mode(5);
    base = vtot;
    meas_in = 1'b1; tick(8);
    cnt_en = 1'b0; tick(5);
    cnt_en = 1'b1; tick(7);
    meas_in = 1'b0; tick(8);
    chk("R8 gated width", int'(log_r[(vtot-1) & 255]), 15);

    // R9 overflow
    go_mode(5);
    meas_in = 1'b1; tick(280);
    chk("R9 ovf set after wrap", int'(ovf), 1);
    tick(20);
    meas_in = 1'b0;
    for (int k = 0; k < 10 && !valid; k++) tick(1);
    chk("R9 ovf with strobe", int'(ovf), 1);
    chk("R9 wrapped width", int'(result), 44);
    tick(1);
    chk("R9 ovf cleared after strobe", int'(ovf), 0);
    tick(6);

    // R10 idle modes and abandoned measurement
    go_mode(3);
    base = vtot;
    pattern(4, 4);
    chk("R10 no strobe in mode 0011", vtot - base, 0);
    go_mode(5);
    r0 = int'(result);
    meas_in = 1'b1; tick(6);
    mode = 4'd0; tick(3);
    mode = 4'd5; tick(3);
    meas_in = 1'b0; tick(8);
    chk("R10 dropped measurement no strobe", vtot - base, 0);
    chk("R10 result unchanged", int'(result), r0);

    finish_run();
  end
endmodule